// File: doc/BRIEF.md
# Bit-Rate Select Clock Generator

This block turns a 3-bit bit-rate select into the timing a voice filter/codec core needs. From the clock input it makes a one-cycle enable at 512 kHz, which the codec core uses in place of a divided clock. When the bit clock is 512 kHz or faster, the bit clock is itself the clock input and the block only divides it. When the bit clock is 128 or 256 kHz, the clock input is a 4096 kHz master clock (within 100 ppm) that runs apart from the slow bit clock. In that case the block brings the bit clock and the 8 kHz strobe into the master domain and marks the middle of each bit cell with a sample enable for the serial port.

The select is registered on every edge. A new value restarts the divider phase. The two codes that have no bit rate raise an error flag and hold the 512 kHz enable low. One 8 kHz frame always holds exactly 64 enables, whatever the rate.

Top module: `rate_clkgen`

## Requirements
- R1: With the select held, en512_o pulses for one cycle on edges div, 2·div, 3·div and so on. Edge 1 is the first rising edge of clk_i at which the select value is registered. The divisor is 1 for select 000 (512 kb/s), 3 for 001 (1536 kb/s), 4 for 010 (2048 kb/s), and 8 for 011 (4096 kb/s), 100 (128 kb/s) and 101 (256 kb/s).
- R2: A change of sel_i restarts the divider, so the first pulse under the new select comes div edges after the change is registered. Writing the same value again does not restart it.
- R3: Over any 64·div consecutive edges with a fixed, valid select, en512_o pulses exactly 64 times (one 8 kHz frame).
- R4: async_o is high exactly when the registered select is 100 or 101. It follows sel_i one edge later.
- R5: The selects 110 and 111 set sel_err_o one edge later and keep en512_o low for as long as they are held.
- R6: While rst_n_i is low, all outputs are low. The first edge after release registers the select as edge 1 of R1.
- R7: In asynchronous mode, a rising edge of bclk_i gives one bit_sample_o pulse that starts at the (H+3)-th clk_i edge after the bit-clock rise. The 3 is two synchronizer flops plus one edge register. H is half a bit cell: 16 master cycles at 128 kb/s and 8 at 256 kb/s.
- R8: A bit-clock rise gives a sample only if strobe_i was high when that rise was taken, so a frame with a slot of n bits gives n samples.
- R9: bit_sample_o stays low in synchronous and reserved modes, even when bclk_i and strobe_i toggle.
- R10: Every bit_sample_o pulse lasts one clk_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock input: the bit clock in synchronous modes, the 4096 kHz master in asynchronous modes |
| rst_n_i | input | 1 | Active-low power-up reset, asynchronous assert |
| sel_i | input | 3 | Bit-rate select |
| bclk_i | input | 1 | Slow bit clock, asynchronous to clk_i |
| strobe_i | input | 1 | 8 kHz channel strobe, active high |
| en512_o | output | 1 | One-cycle 512 kHz enable for the codec core |
| async_o | output | 1 | High in the 128/256 kb/s asynchronous modes |
| sel_err_o | output | 1 | Reserved select code registered |
| bit_sample_o | output | 1 | Mid-bit sample enable in asynchronous mode |

## Verification
The divider is driven by each select held steady, which pins down every divisor and the phase of the first pulse. It is then driven by random select changes at random spacings, including rewrites of the same code. These separate a true phase restart from a divider that free-runs, and they show a reserved code suppressing the enable. Whole frames are counted per rate to confirm 64 enables each. Asynchronous bit clocks with random high and low times and slots of one to eight bits separate correct mid-cell timing and strobe gating from off-by-one synchronizer latency. Toggling bclk_i in the synchronous modes shows that the sample output stays silent there.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
   localparam int DIV_W = 4;
   typedef logic [2:0]       rsel_t;
   typedef logic [DIV_W-1:0] div_t;

   function automatic div_t div_of(rsel_t s);
      case (s)
         3'b000:  return div_t'(1);
         3'b001:  return div_t'(3);
         3'b010:  return div_t'(4);
         default: return div_t'(8);
      endcase
   endfunction

   function automatic logic is_async(rsel_t s);
      return (s == 3'b100) || (s == 3'b101);
   endfunction

   function automatic logic is_rsvd(rsel_t s);
      return s[2] & s[1];
   endfunction
endpackage

// File: rtl/rcg_mode.sv
module rcg_mode
   import rcg_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_n_i,
   input  rsel_t sel_i,
   output logic  live_o,
   output logic  restart_o,
   output div_t  div_o,
   output logic  async_o,
   output logic  rsvd_o,
   output logic  fast_o
);
   rsel_t sel_q;
   logic  live_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         sel_q  <= '0;
         live_q <= 1'b0;
      end else begin
         sel_q  <= sel_i;
         live_q <= 1'b1;
      end
   end

   always_comb begin
      live_o    = live_q;
      restart_o = !live_q || (sel_i != sel_q);
      div_o     = div_of(sel_q);
      async_o   = live_q && is_async(sel_q);
      rsvd_o    = live_q && is_rsvd(sel_q);
      fast_o    = sel_q[0];
   end
endmodule

// File: rtl/rcg_div.sv
module rcg_div
   import rcg_pkg::*;
(
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic restart_i,
   input  logic run_i,
   input  div_t div_i,
   output logic en_o
);
   div_t cnt_q;
   logic wrap;

   assign wrap = (cnt_q == div_i - div_t'(1));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)       cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (wrap)      cnt_q <= '0;
      else                cnt_q <= cnt_q + div_t'(1);
   end

   assign en_o = run_i && wrap;
endmodule

// File: rtl/rcg_bitsync.sv
module rcg_bitsync #(
   parameter int STAGES    = 2,
   parameter int HALF_SLOW = 16,
   parameter int HALF_FAST = 8,
   localparam int CW       = $clog2(HALF_SLOW + 1)
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic bclk_i,
   input  logic stb_i,
   input  logic async_i,
   input  logic fast_i,
   output logic sample_o
);
   logic [STAGES-1:0] bc_sh, st_sh;
   logic              bc_last, rise, armed_q, slot_q, samp_q;
   logic [CW-1:0]     cnt_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            bc_sh[g] <= 1'b0;
            st_sh[g] <= 1'b0;
         end else if (g == 0) begin
            bc_sh[g] <= bclk_i;
            st_sh[g] <= stb_i;
         end else begin
            bc_sh[g] <= bc_sh[(g == 0) ? 0 : g-1];
            st_sh[g] <= st_sh[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign rise = bc_sh[STAGES-1] & ~bc_last;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         bc_last <= 1'b0;
         armed_q <= 1'b0;
         slot_q  <= 1'b0;
         samp_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         bc_last <= bc_sh[STAGES-1];
         samp_q  <= 1'b0;
         if (rise) begin
            armed_q <= 1'b1;
            slot_q  <= st_sh[STAGES-1];
            cnt_q   <= fast_i ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
         end else if (armed_q) begin
            if (cnt_q == '0) begin
               armed_q <= 1'b0;
               samp_q  <= slot_q && async_i;
            end else begin
               cnt_q <= cnt_q - CW'(1);
            end
         end
      end
   end

   assign sample_o = samp_q;
endmodule

// File: rtl/rate_clkgen.sv
module rate_clkgen #(
   parameter int MASTER_KHZ  = 4096,
   parameter int SLOW_KHZ    = 128,
   parameter int FAST_KHZ    = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_n_i,
   input  logic [2:0] sel_i,
   input  logic       bclk_i,
   input  logic       strobe_i,
   output logic       en512_o,
   output logic       async_o,
   output logic       sel_err_o,
   output logic       bit_sample_o
);
   import rcg_pkg::*;

   localparam int HALF_SLOW = MASTER_KHZ / SLOW_KHZ / 2;
   localparam int HALF_FAST = MASTER_KHZ / FAST_KHZ / 2;

   if (SYNC_STAGES < 2 || HALF_FAST < 2 || HALF_SLOW < HALF_FAST ||
       (MASTER_KHZ % (2 * FAST_KHZ)) != 0 || (MASTER_KHZ % (2 * SLOW_KHZ)) != 0) begin : g_bad_cfg
      $error("rate_clkgen: unsupported parameter set");
   end

   logic live, restart, async_m, rsvd, fast, en_raw;
   div_t div;

   rcg_mode u_mode (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .sel_i(sel_i),
      .live_o(live), .restart_o(restart), .div_o(div),
      .async_o(async_m), .rsvd_o(rsvd), .fast_o(fast)
   );

   rcg_div u_div (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .restart_i(restart),
      .run_i(live && !rsvd), .div_i(div), .en_o(en_raw)
   );

   rcg_bitsync #(
      .STAGES(SYNC_STAGES), .HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)
   ) u_bsync (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .bclk_i(bclk_i), .stb_i(strobe_i),
      .async_i(async_m), .fast_i(fast), .sample_o(bit_sample_o)
   );

   assign en512_o   = en_raw;
   assign async_o   = async_m;
   assign sel_err_o = rsvd;
endmodule

// File: rtl/rate_clkgen_chk.sv
module rate_clkgen_chk (
   input logic       clk_i,
   input logic       rst_n_i,
   input logic [2:0] sel_i,
   input logic       en512_o,
   input logic       async_o,
   input logic       sel_err_o,
   input logic       bit_sample_o
);
   AST_RSVD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      sel_err_o |-> !en512_o); // R5
   AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(async_o && sel_err_o)); // R4
   AST_DIV8_GAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (en512_o && sel_i == 3'b011 && $past(sel_i) == 3'b011) |=> !en512_o); // R1
   AST_SAMPLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      bit_sample_o |=> !bit_sample_o); // R10
   AST_SYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!async_o && $past(!async_o)) |-> !bit_sample_o); // R9
endmodule

bind rate_clkgen rate_clkgen_chk u_chk (
   .clk_i(clk_i), .rst_n_i(rst_n_i), .sel_i(sel_i), .en512_o(en512_o),
   .async_o(async_o), .sel_err_o(sel_err_o), .bit_sample_o(bit_sample_o)
);

// File: tb/rate_clkgen_test.sv
module rate_clkgen_test;
   logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, stb = 1'b0;
   logic [2:0] sel = 3'b000;
   logic en512, async_f, err_f, samp;

   int checks = 0, errors = 0, edge_n = 0;
   int m_start = 0;
   logic [2:0] m_sel = 3'b000;
   logic in_rst = 1'b1;
   logic exp_s [0:255];
   logic prev_exp_s = 1'b0;
   int en_cnt = 0;

   rate_clkgen uut (
      .clk_i(clk), .rst_n_i(rst_n), .sel_i(sel), .bclk_i(bclk), .strobe_i(stb),
      .en512_o(en512), .async_o(async_f), .sel_err_o(err_f), .bit_sample_o(samp)
   );

   always #4 clk = ~clk;
   always @(posedge clk) edge_n++;

   function automatic int f_div(logic [2:0] s);
      case (s) 3'b000: return 1; 3'b001: return 3; 3'b010: return 4; default: return 8; endcase
   endfunction
   function automatic logic f_async(logic [2:0] s); return s == 3'b100 || s == 3'b101; endfunction
   function automatic logic f_rsv(logic [2:0] s); return s == 3'b110 || s == 3'b111; endfunction
   function automatic int f_half(logic [2:0] s); return (s == 3'b101) ? 8 : 16; endfunction

   task automatic cmp(logic act, logic exp, string tag, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at edge %0d: actual %b expected %b", tag, what, edge_n, act, exp);
      end
   endtask

   task automatic check();
      logic e_en, e_as, e_er, e_s;
      int ph;
      string tg;
      e_s = exp_s[edge_n % 256];
      exp_s[edge_n % 256] = 1'b0;
      if (in_rst) begin
         cmp(en512, 1'b0, "R6", "en512"); cmp(async_f, 1'b0, "R6", "async");
         cmp(err_f, 1'b0, "R6", "err");   cmp(samp, 1'b0, "R6", "sample");
      end else begin
         ph   = edge_n - m_start;
         e_en = !f_rsv(m_sel) && ((ph % f_div(m_sel)) == f_div(m_sel) - 1);
         e_as = f_async(m_sel);
         e_er = f_rsv(m_sel);
         tg = f_rsv(m_sel) ? "R5" : ((ph < f_div(m_sel)) ? "R2" : "R1");
         cmp(en512, e_en, tg, "en512");
         cmp(async_f, e_as, "R4", "async");
         cmp(err_f, e_er, "R5", "err");
         tg = e_s ? "R7" : (prev_exp_s ? "R10" : (f_async(m_sel) ? "R8" : "R9"));
         cmp(samp, e_s, tg, "sample");
      end
      prev_exp_s = e_s;
      en_cnt += int'(en512);
   endtask

   task automatic cyc(int n, logic toggle);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check();
         if (toggle) begin bclk = 1'($urandom); stb = 1'($urandom); end
      end
   endtask

   task automatic set_sel(logic [2:0] s);
      sel = s;
      if (s != m_sel) begin m_sel = s; m_start = edge_n + 1; end
   endtask

   task automatic async_frames(logic [2:0] s, int nfr);
      int h, lo, nb, hf;
      hf = f_half(s);
      @(negedge clk); check(); set_sel(s);
      cyc(30, 1'b0);
      for (int f = 0; f < nfr; f++) begin
         nb = $urandom_range(1, 8);
         for (int b = 0; b < 16; b++) begin
            h  = hf + $urandom_range(0, 2) - 1;
            lo = hf + $urandom_range(0, 2) - 1;
            @(negedge clk); check();
            bclk = 1'b1; stb = (b < nb);
            if (stb) exp_s[(edge_n + 3 + hf) % 256] = 1'b1; // R7 R8
            cyc(h - 1, 1'b0);
            @(negedge clk); check(); bclk = 1'b0;
            cyc(lo - 1, 1'b0);
         end
      end
      stb = 1'b0;
      cyc(40, 1'b0);
   endtask

   task automatic frame_count(logic [2:0] s);
      @(negedge clk); check(); set_sel(s);
      cyc(17, 1'b0);
      en_cnt = 0;
      cyc(64 * f_div(s), 1'b0);
      checks++;
      if (en_cnt != 64) begin
         errors++;
         $display("FAIL R3 frame count sel %b: actual %0d expected 64", s, en_cnt);
      end
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1a2b));
      for (int i = 0; i < 256; i++) exp_s[i] = 1'b0;
      sel = 3'b010;
      cyc(5, 1'b0);                                  // R6 reset state
      @(negedge clk); check();
      rst_n = 1'b1; in_rst = 1'b0; m_sel = 3'b010; m_start = edge_n + 1;
      cyc(20, 1'b0);
      for (int s = 0; s < 8; s++) begin              // R1 R4 R5 R9 each select
         @(negedge clk); check(); set_sel(3'(s));
         if (s < 4) begin cyc(40, 1'b1); bclk = 1'b0; stb = 1'b0; cyc(30, 1'b0); end
         else cyc(40, 1'b0);
      end
      for (int s = 0; s < 6; s++) frame_count(3'(s)); // R3
      for (int i = 0; i < 300; i++) begin             // R2 random changes
         @(negedge clk); check();
         if ($urandom_range(0, 3) == 0) set_sel(m_sel);
         else set_sel(3'($urandom_range(0, 7)));
         cyc($urandom_range(0, 20), 1'b0);
      end
      async_frames(3'b100, 3);                       // R7 R8 R10 slow
      async_frames(3'b101, 3);                       // R7 R8 R10 fast
      @(negedge clk); check(); set_sel(3'b011);
      cyc(20, 1'b0);
      @(negedge clk); check();                       // R6 reset again
      rst_n = 1'b0; in_rst = 1'b1;
      cyc(4, 1'b0);
      @(negedge clk); check();
      set_sel(3'b001); rst_n = 1'b1; in_rst = 1'b0; m_start = edge_n + 1;
      cyc(20, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule